// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem control register of a 16550-style serial port and produces the matching modem status byte. Software writes the control register through a write strobe and 8-bit write data. The status byte is always visible on an output. A read strobe marks the cycle in which software takes the status byte; on that clock edge the change bits are cleared.

The line half of the status byte is derived from the control register. With loopback selected, each control output is routed internally onto a status input. Otherwise carrier detect and data set ready read as asserted and the other inputs read as idle. Each control write compares the derived line bits before and after the write and latches change bits. A flag output tells the interrupt logic outside the block that at least one change bit is pending. Physical modem pins, interrupt priority and address decode are handled elsewhere.

Top module: `mdm_ctl_stat`

## Requirements
- R1: A control write stores write data bits 4:0 (0 = DTR, 1 = RTS, 2 = OUT1, 3 = OUT2, 4 = loopback). The control readback shows those bits, and its bits 7:5 always read 0.
- R2: With loopback set, status bit 4 (CTS) follows RTS, bit 5 (DSR) follows DTR, bit 6 (RI) follows OUT1 and bit 7 (DCD) follows OUT2.
- R3: With loopback clear, status bits 7:4 read 4'b1010 (DCD and DSR high, RI and CTS low).
- R4: A control write that changes CTS, DSR or DCD sets status bit 0, 1 or 3 respectively.
- R5: Status bit 2 is set by a control write only when RI goes from 1 to 0. A rising RI leaves it unchanged.
- R6: Change bits stay set across later control writes and idle cycles until a status read.
- R7: During a read strobe the status output shows the full current value. At that edge, bits 3:0 are cleared, except that change bits raised by a control write in the same cycle remain set.
- R8: The change flag output is high exactly when any of status bits 3:0 is set.
- R9: After reset the control register is 0, the status byte is 8'hA0 and the change flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_o | output | 8 | Control register readback |
| stat_re_i | input | 1 | Status read strobe; clears change bits at the edge |
| stat_o | output | 8 | Status byte: line bits 7:4, change bits 3:0 |
| chg_o | output | 1 | High while any change bit is set |

## Verification
Random mixes of writes, reads and idle cycles move the port in and out of loopback with arbitrary control values. This reaches every line transition, including changes caused only by entering or leaving loopback. Directed sequences toggle OUT1 up and then down, which separates the falling-edge-only ring rule from a plain change detector. A write issued in the same cycle as a read shows whether fresh change bits survive the clear. Sequences that leave out reads show whether set bits are wrongly dropped.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned LINE_W = 4;
  // control bit positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;
  // line bit positions (status bits 7:4 shifted down)
  localparam int unsigned L_CTS  = 0;
  localparam int unsigned L_DSR  = 1;
  localparam int unsigned L_RI   = 2;
  localparam int unsigned L_DCD  = 3;
  localparam logic [LINE_W-1:0] LINE_IDLE = 4'b1010;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [CTRL_W-1:0] ctrl_q_o,
  output logic [CTRL_W-1:0] ctrl_nxt_o
);
  logic [CTRL_W-1:0] ctrl_q;

  assign ctrl_nxt_o = we_i ? wdata_i[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_nxt_o;
  end

  assign ctrl_q_o = ctrl_q;

  p_ctrl_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
  p_ctrl_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_q == $past(wdata_i[CTRL_W-1:0]));
endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
  import mdm_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [LINE_W-1:0] line_o
);
  always_comb begin
    if (ctrl_i[C_LOOP]) begin
      line_o        = '0;
      line_o[L_CTS] = ctrl_i[C_RTS];
      line_o[L_DSR] = ctrl_i[C_DTR];
      line_o[L_RI]  = ctrl_i[C_OUT1];
      line_o[L_DCD] = ctrl_i[C_OUT2];
    end else begin
      line_o = LINE_IDLE;
    end
  end
endmodule

// File: rtl/mdm_delta_trk.sv
module mdm_delta_trk
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              clr_i,
  input  logic [LINE_W-1:0] line_old_i,
  input  logic [LINE_W-1:0] line_new_i,
  output logic [LINE_W-1:0] delta_o,
  output logic              flag_o
);
  logic [LINE_W-1:0] delta_q, hit;

  // per-bit change detect; ring bit only on trailing edge
  for (genvar i = 0; i < LINE_W; i++) begin : g_hit
    if (i == L_RI) begin : g_fall
      assign hit[i] = upd_i & line_old_i[i] & ~line_new_i[i];
    end else begin : g_chg
      assign hit[i] = upd_i & (line_old_i[i] ^ line_new_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delta_q <= '0;
    else         delta_q <= (clr_i ? '0 : delta_q) | hit;
  end

  assign delta_o = delta_q;
  assign flag_o  = |delta_q;

  p_teri_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !delta_q[L_RI] && !line_old_i[L_RI]) |=> !delta_q[L_RI]);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (delta_q & $past(delta_q)) == $past(delta_q));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> delta_q == '0);
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  input  logic             stat_re_i,
  output logic [REG_W-1:0] stat_o,
  output logic             chg_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic [LINE_W-1:0] line_cur, line_nxt, delta;

  mdm_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .ctrl_q_o  (ctrl_q),
    .ctrl_nxt_o(ctrl_nxt)
  );

  mdm_line_map u_map_cur (.ctrl_i(ctrl_q),   .line_o(line_cur));
  mdm_line_map u_map_nxt (.ctrl_i(ctrl_nxt), .line_o(line_nxt));

  mdm_delta_trk u_delta (
    .clk_i, .rst_ni,
    .upd_i     (ctrl_we_i),
    .clr_i     (stat_re_i),
    .line_old_i(line_cur),
    .line_new_i(line_nxt),
    .delta_o   (delta),
    .flag_o    (chg_o)
  );

  assign ctrl_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
  assign stat_o = {line_cur, delta};

  p_ctrl_upper_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[REG_W-1:CTRL_W] == '0);
  p_loop_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[C_LOOP] |-> stat_o[7:4] ==
      {ctrl_o[C_OUT2], ctrl_o[C_OUT1], ctrl_o[C_DTR], ctrl_o[C_RTS]});
  p_idle_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[C_LOOP] |-> stat_o[7:4] == 4'b1010);
  p_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o == (stat_o[3:0] != '0));
endmodule

// File: tb/mdm_ctl_stat_bench.sv
module mdm_ctl_stat_bench;
  logic       clk = 0, rst_n = 0;
  logic       we = 0, re = 0;
  logic [7:0] wd = 0;
  logic [7:0] ctrl_o, stat_o;
  logic       chg_o;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  logic [4:0] m_ctrl;
  logic [3:0] m_delta;

  always #5 clk = ~clk;

  mdm_ctl_stat u_mdm_ctl_stat (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .ctrl_o(ctrl_o), .stat_re_i(re), .stat_o(stat_o), .chg_o(chg_o));

  function automatic logic [3:0] line_of(logic [4:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return 4'b1010;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R1", ctrl_o, {3'b0, m_ctrl});
    chk(m_ctrl[4] ? "R2" : "R3", {stat_o[7:4], 4'h0}, {line_of(m_ctrl), 4'h0});
    chk("R4/R5/R6", {4'h0, stat_o[3:0]}, {4'h0, m_delta});
    chk("R8", {7'h0, chg_o}, {7'h0, |m_delta});
  endtask

  task automatic step(bit w, logic [7:0] d, bit r);
    logic [3:0] o, n, hit;
    @(negedge clk);
    we = w; wd = d; re = r;
    if (r) chk("R7", stat_o, {line_of(m_ctrl), m_delta});
    @(posedge clk);
    o = line_of(m_ctrl);
    if (w) m_ctrl = d[4:0];
    n = line_of(m_ctrl);
    hit = w ? (((o ^ n) & 4'b1011) | (o & ~n & 4'b0100)) : 4'h0;
    m_delta = (r ? 4'h0 : m_delta) | hit;
    @(negedge clk);
    we = 0; re = 0;
    chk_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ctrl = 0; m_delta = 0;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9", ctrl_o, 8'h00);
    chk("R9", stat_o, 8'hA0);
    chk("R9", {7'h0, chg_o}, 8'h00);
    rst_n = 1;
    // R1 upper bits masked
    step(1, 8'hE0, 0);
    // R2 enter loopback, all lines low -> DSR,DCD deltas
    step(1, 8'h10, 0);
    // R5 RI rising: no trailing-edge bit
    step(1, 8'h14, 1);
    step(1, 8'h14, 0);
    // R5 RI falling sets it
    step(1, 8'h10, 0);
    // R6 sticky across writes and idle
    step(1, 8'h11, 0);
    step(0, 8'h00, 0);
    // R7 read clears
    step(0, 8'h00, 1);
    // R7 write and read in same cycle keeps new delta
    step(1, 8'h13, 1);
    step(0, 8'h00, 1);
    // R3 leave loopback
    step(1, 8'h0F, 0);
    step(0, 8'h00, 1);
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 3) == 0);
    finish_run();
  end
endmodule